// File: doc/BRIEF.md
# Saturating Lane Shift-Left Unit

This unit is one execution stage of a packed-integer vector datapath. On each start strobe it takes a 64-bit or 128-bit operand and a 7-bit size/shift code. The code gives both the lane width and the left-shift distance. Every lane is shifted left and then clamped to the range of the destination type.

The type bit and the op bit pick the signedness of the source and of the destination separately. A signed source can therefore be narrowed into an unsigned result. Any lane that clamps raises a one-cycle saturation pulse and sets a sticky flag, which holds until a clear strobe arrives.

Encodings the unit cannot execute are flagged as invalid and have no side effects. Register storage, operand fetch and the wider instruction decode sit outside the unit.

Top module: `simd_qshl_unit`

## Requirements
- R1: Call the 7-bit code c[6:0]. The lane width is 64 if c[6]=1, else 32 if c[5]=1, else 16 if c[4]=1, else 8 if c[3]=1. The shift distance is c minus the lane width, which is 0 to width-1.
- R2: bad_enc is 1 for the operation if any of these holds: c[6:3]=0, u_bit=0 with op_bit=0, or wide=1 with dst_odd or src_odd set.
- R3: Source lanes are unsigned only when u_bit=1 and op_bit=1, and are otherwise sign-extended. The destination is unsigned exactly when u_bit=1.
- R4: With a signed destination, each result lane is the shifted value clamped to [-2^(W-1), 2^(W-1)-1], where W is the lane width. A clamped lane counts as saturated, and a shift of 0 never saturates.
- R5: With an unsigned destination, each result lane is the shifted value clamped to [0, 2^W-1]. A negative signed source lane gives 0 and counts as saturated.
- R6: With wide=0 only operand[63:0] is processed. result[127:64] is 0, and the upper operand lanes cannot cause saturation.
- R7: result, bad_enc and sat_pulse appear at the rising edge after the edge that samples start=1, and out_valid is 1 for that one cycle. sat_pulse is 1 when any processed lane saturated.
- R8: An invalid operation leaves result unchanged, gives sat_pulse=0 and leaves sat_sticky unchanged.
- R9: sat_sticky is set by any saturating valid operation and holds until clr_flag. If clr_flag and a saturating operation occur in the same cycle, the flag ends up set.
- R10: While rst_n is low, out_valid, result, bad_enc, sat_pulse and sat_sticky are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch an operation this cycle |
| operand | input | 128 | Source lanes (only [63:0] used when wide=0) |
| size_shift | input | 7 | Combined lane-size and shift code |
| u_bit | input | 1 | Type bit: destination unsigned when 1 |
| op_bit | input | 1 | Op bit: with u_bit=1, source unsigned when 1 |
| wide | input | 1 | 1 selects 128-bit operation, 0 selects 64-bit |
| dst_odd | input | 1 | Lowest bit of the destination register index |
| src_odd | input | 1 | Lowest bit of the source register index |
| clr_flag | input | 1 | Clear the sticky saturation flag |
| out_valid | output | 1 | Result cycle marker |
| result | output | 128 | Saturated lanes |
| bad_enc | output | 1 | Operation was an invalid encoding |
| sat_pulse | output | 1 | At least one lane clamped in this operation |
| sat_sticky | output | 1 | Cumulative saturation flag |

## Verification
Every result of an operation is due exactly one clock after the edge that samples start: result, bad_enc, sat_pulse and the updated sat_sticky all change on that single edge. The driver applies inputs on a falling edge and pushes the expected item at the same moment. The monitor pops an item only on the next falling edge where out_valid is high, so each comparison lands half a cycle after the edge that produced it. A clear issued without an operation is checked on the falling edge after the clear was sampled.

// File: rtl/simd_qshl_unit.sv
module simd_qshl_unit (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [127:0] operand,
  input  logic [6:0]   size_shift,
  input  logic         u_bit,
  input  logic         op_bit,
  input  logic         wide,
  input  logic         dst_odd,
  input  logic         src_odd,
  input  logic         clr_flag,
  output logic         out_valid,
  output logic [127:0] result,
  output logic         bad_enc,
  output logic         sat_pulse,
  output logic         sat_sticky
);
  localparam int VW = 128;
  localparam int RW = 64;

  wire src_uns = u_bit & op_bit;
  wire dst_uns = u_bit;
  wire bad_now = (size_shift[6:3] == 4'd0) | (~u_bit & ~op_bit) | (wide & (dst_odd | src_odd));

  logic [1:0] sel;
  assign sel = size_shift[6] ? 2'd3 : size_shift[5] ? 2'd2 : size_shift[4] ? 2'd1 : 2'd0;

  logic [3:0][VW-1:0] cand;
  logic [3:0]         cand_sat;

  for (genvar g = 0; g < 4; g++) begin : g_size
    localparam int S  = 8 << g;
    localparam int NL = VW / S;
    wire [6:0] amt = size_shift & 7'(S - 1);
    logic [NL-1:0] lsat;
    for (genvar l = 0; l < NL; l++) begin : g_lane
      localparam bit HI = (l * S >= RW);
      wire [S-1:0] ln  = operand[l*S +: S];
      wire [2*S:0] ext = {{(S+1){ln[S-1] & ~src_uns}}, ln};
      wire [2*S:0] sh  = ext << amt;
      wire neg   = sh[2*S];
      wire u_ovf = |sh[2*S-1:S];
      wire s_ok  = (&sh[2*S:S-1]) | ~(|sh[2*S:S-1]);
      wire live  = wide | ~HI;
      logic [S-1:0] val;
      logic         sat;
      always_comb begin
        if (dst_uns) begin
          sat = neg | u_ovf;
          val = neg ? '0 : (u_ovf ? '1 : sh[S-1:0]);
        end else begin
          sat = ~s_ok;
          val = s_ok ? sh[S-1:0] : {neg, {(S-1){~neg}}};
        end
      end
      assign lsat[l] = sat & live;
      assign cand[g][l*S +: S] = live ? val : '0;
    end
    assign cand_sat[g] = |lsat;
  end

  wire sat_now = start & ~bad_now & cand_sat[sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      result     <= '0;
      bad_enc    <= 1'b0;
      sat_pulse  <= 1'b0;
      sat_sticky <= 1'b0;
    end else begin
      out_valid <= start;
      bad_enc   <= start & bad_now;
      sat_pulse <= sat_now;
      if (start & ~bad_now) result <= cand[sel];
      if (clr_flag | sat_now) sat_sticky <= sat_now;
    end
  end

  assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> out_valid);
  assert_bad_holds_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && bad_enc) |-> result == $past(result));
  assert_bad_no_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bad_enc |-> !sat_pulse);
  assert_pulse_sets_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sat_pulse |-> sat_sticky);
  assert_sticky_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_sticky && !clr_flag) |=> sat_sticky);
  assert_narrow_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !bad_enc && !$past(wide)) |-> result[127:64] == 64'd0);
endmodule

// File: tb/test_simd_qshl_unit.sv
module test_simd_qshl_unit;
  logic clk = 0, rst_n = 0, start = 0;
  logic [127:0] operand = '0;
  logic [6:0] size_shift = '0;
  logic u_bit = 0, op_bit = 0, wide = 0, dst_odd = 0, src_odd = 0, clr_flag = 0;
  logic out_valid, bad_enc, sat_pulse, sat_sticky;
  logic [127:0] result;

  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  simd_qshl_unit i_simd_qshl_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .operand(operand), .size_shift(size_shift),
    .u_bit(u_bit), .op_bit(op_bit), .wide(wide), .dst_odd(dst_odd), .src_odd(src_odd),
    .clr_flag(clr_flag), .out_valid(out_valid), .result(result), .bad_enc(bad_enc),
    .sat_pulse(sat_pulse), .sat_sticky(sat_sticky));

  typedef struct {
    logic [127:0] res;
    logic bad, pulse, sticky;
    string tag;
  } item_t;
  item_t sb[$];
  logic [127:0] last_res = '0;
  logic exp_sticky = 0;

  task automatic check(input string tag, input string what, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model(input logic [127:0] x, input logic [6:0] c, input logic u, input logic o,
                       input logic w, input logic dodd, input logic sodd, output item_t it);
    int size, amt, nl;
    logic signed [130:0] v, lo, hi;
    it.bad = (c[6:3] == 0) || (!u && !o) || (w && (dodd || sodd));
    it.res = last_res;
    it.pulse = 0;
    if (!it.bad) begin
      size = c[6] ? 64 : c[5] ? 32 : c[4] ? 16 : 8;
      amt = int'(c) - size;
      nl = (w ? 128 : 64) / size;
      it.res = '0;
      if (u) begin lo = 0; hi = (131'sd1 <<< size) - 1; end
      else begin lo = -(131'sd1 <<< (size-1)); hi = (131'sd1 <<< (size-1)) - 1; end
      for (int l = 0; l < nl; l++) begin
        v = '0;
        for (int b = 0; b < size; b++) v[b] = x[l*size+b];
        if (!(u && o) && x[l*size+size-1]) for (int b = size; b < 131; b++) v[b] = 1'b1;
        v = v <<< amt;
        if (v > hi) begin v = hi; it.pulse = 1; end
        if (v < lo) begin v = lo; it.pulse = 1; end
        for (int b = 0; b < size; b++) it.res[l*size+b] = v[b];
      end
      last_res = it.res;
    end
  endtask

  task automatic op(input string tag, input logic [127:0] x, input logic [6:0] c, input logic u,
                    input logic o, input logic w, input logic dodd, input logic sodd, input logic clr);
    item_t it;
    @(negedge clk);
    model(x, c, u, o, w, dodd, sodd, it);
    exp_sticky = it.pulse ? 1'b1 : (clr ? 1'b0 : exp_sticky);
    it.sticky = exp_sticky;
    it.tag = tag;
    sb.push_back(it);
    operand = x; size_shift = c; u_bit = u; op_bit = o; wide = w;
    dst_odd = dodd; src_odd = sodd; clr_flag = clr; start = 1;
  endtask

  task automatic idle;
    @(negedge clk);
    start = 0; clr_flag = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sb.size() == 0) begin
        checks++; failures++;
        $display("FAIL R7 unexpected out_valid actual=1 expected=0");
      end else begin
        item_t it;
        it = sb.pop_front();
        check(it.tag, "bad_enc", 128'(bad_enc), 128'(it.bad));
        check(it.tag, "result", result, it.res);
        check(it.tag, "sat_pulse", 128'(sat_pulse), 128'(it.pulse));
        check(it.tag, "sat_sticky", 128'(sat_sticky), 128'(it.sticky));
      end
    end
  end

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10", "out_valid in reset", 128'(out_valid), 0);
    check("R10", "result in reset", result, 0);
    check("R10", "flags in reset", {125'd0, bad_enc, sat_pulse, sat_sticky}, 0);
    rst_n = 1;
    // R1 R4 8-bit lanes, signed, shift 3
    op("R1_R4_s8", 128'h05_10_F0_E0_7F_80_01_FF_00_0C_F4_11_EE_03_FD_40, 7'b0001_011, 0, 1, 1, 0, 0, 0);
    // R4 shift 0 never saturates, 16-bit
    op("R4_s16_zero", 128'h7FFF_8000_1234_FEDC_0001_FFFF_4000_C000, 7'b0010_000, 0, 1, 1, 0, 0, 0);
    // R3 R5 signed source into unsigned 32-bit lanes
    op("R3_R5_su32", 128'hFFFF_FFF0_0000_0100_4000_0000_0000_0001, 7'b0100_100, 1, 0, 1, 0, 0, 0);
    // R3 R5 unsigned source 64-bit, shift 63
    op("R3_R5_uu64", 128'h0000_0000_0000_0001_8000_0000_0000_0001, 7'b1111_111, 1, 1, 1, 0, 0, 0);
    // R3 unsigned source 8-bit, high-bit lanes are large positives
    op("R3_uu8", 128'h80_FF_01_7F_00_10_20_40_81_02_03_04_05_06_07_08, 7'b0001_001, 1, 1, 1, 0, 0, 0);
    // R6 narrow op: upper half would saturate but is ignored
    op("R6_narrow", 128'h7F7F_7F7F_7F7F_7F7F_0102_0304_0506_0708, 7'b0001_010, 0, 1, 0, 1, 1, 0);
    idle();
    // R9 clear alone
    @(negedge clk); clr_flag = 1;
    exp_sticky = 0;
    @(negedge clk); clr_flag = 0;
    check("R9", "sticky after clear", 128'(sat_sticky), 0);
    // R2 R8 invalid encodings
    op("R2_R8_zero_code", 128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 7'b0000_101, 0, 1, 1, 0, 0, 0);
    op("R2_R8_u0op0", 128'h7F7F_7F7F_7F7F_7F7F_7F7F_7F7F_7F7F_7F7F, 7'b0001_111, 0, 0, 1, 0, 0, 0);
    op("R2_R8_odd_dst", 128'h7F7F_7F7F_7F7F_7F7F_7F7F_7F7F_7F7F_7F7F, 7'b0001_111, 0, 1, 1, 1, 0, 0);
    op("R2_R8_odd_src", 128'h7F7F_7F7F_7F7F_7F7F_7F7F_7F7F_7F7F_7F7F, 7'b0001_111, 1, 1, 1, 0, 1, 0);
    // R9 saturate, then clear and saturate together
    op("R9_set", 128'h4000_0000_0000_0000_0000_0000_0000_0000, 7'b1000_010, 0, 1, 1, 0, 0, 0);
    op("R9_clr_and_sat", 128'h4000_0000_0000_0000_0000_0000_0000_0000, 7'b1000_010, 0, 1, 1, 0, 0, 1);
    op("R9_clr_no_sat", 128'h1, 7'b1000_000, 0, 1, 1, 0, 0, 1);
    idle();
    // R1 R7 mixed back-to-back operations
    for (int k = 0; k < 60; k++) begin
      logic [127:0] x;
      x = {$urandom, $urandom, $urandom, $urandom};
      op("R1_R7_mix", x, 7'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
         1'(($urandom % 8) == 0), 1'(($urandom % 8) == 0), 1'(($urandom % 6) == 0));
    end
    idle();
    repeat (3) @(negedge clk);
    check("R7", "scoreboard drained", 128'(sb.size()), 0);
    check("R7", "out_valid idle", 128'(out_valid), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule